// File: doc/BRIEF.md
# Windowed Summed-Area Table with Rectangle Sum

This block builds a summed-area table for a single square detection window of grayscale pixels. The default window is 24x24 with 8-bit pixels. Keeping the table to one window, instead of a whole frame, keeps its storage to a few hundred entries. Pixels arrive one per accepted cycle in row-major order. Each table entry is formed as the pixel is written, from the running sum of the current row plus the entry in the same column of the row above.

Once the last pixel of the window has been written, a ready flag rises and the block accepts rectangle queries. A query gives the top row, left column, height and width of a rectangle. Three cycles later a strobe returns the sum of every pixel inside that rectangle. Every query takes the same time, whatever the rectangle's size, because the sum always comes from four corner entries combined by two adders and one subtractor. These sums are the raw material for Haar-like feature evaluation further down the pipeline.

A start pulse begins a new window. It clears the ready flag and rewrites the table in place.

Top module: `sat_window_sum`

## Requirements
- R1: After reset, `win_ready` is 0 and `res_valid` is 0.
- R2: Pixels are accepted when `pix_valid` is 1, in row-major order: index = row*WIN + column, with column 0 of each row first. Cycles with `pix_valid` low are not counted. `win_ready` stays 0 while the last pixel (index WIN*WIN-1) is presented and reads 1 after the clock edge that accepts it.
- R3: Table entry (i,j) equals the sum of all pixels in rows 0..i and columns 0..j. A query with row 0, column 0, height i+1 and width j+1 returns that entry.
- R4: A query returns the exact pixel sum of the rectangle with top-left (`q_row`,`q_col`), `q_height` rows and `q_width` columns. This holds for any rectangle inside the window, including rectangles on row 0 or column 0, where the missing corners count as zero.
- R5: A query accepted at a clock edge (`q_valid`=1 while `win_ready`=1) produces `res_valid`=1 for one cycle after exactly the third edge. The latency does not depend on the rectangle's size. Queries on consecutive cycles give results on consecutive cycles.
- R6: A query presented while `win_ready` is 0 is ignored: no `res_valid` follows.
- R7: A `start` pulse sets `win_ready` to 0 after its edge and restarts loading at index 0. A pixel presented in the same cycle as `start` is dropped. Queries after the new load reflect only the new pixels.
- R8: Pixels presented while `win_ready` is 1, with no `start`, are ignored and leave the table unchanged.
- R9: Sums do not overflow. A window of all-255 pixels gives a full-window sum of 255*576 = 146880 on the 18-bit `res_sum`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin loading a new window |
| pix_valid | input | 1 | Pixel present on `pix_data` |
| pix_data | input | 8 | Grayscale pixel value |
| win_ready | output | 1 | Table holds a complete window |
| q_valid | input | 1 | Rectangle query present |
| q_row | input | 5 | Top row of the rectangle |
| q_col | input | 5 | Left column of the rectangle |
| q_height | input | 5 | Rows in the rectangle (1..24) |
| q_width | input | 5 | Columns in the rectangle (1..24) |
| res_valid | output | 1 | Rectangle sum valid strobe |
| res_sum | output | 18 | Rectangle pixel sum |

## Verification
Several properties are checked on every cycle by assertions. A result strobe appears exactly three cycles after each accepted query and at no other time. The ready flag rises only on acceptance of the final pixel and drops after every start. No table write happens once the window is full. The positive corner pair never falls below the negative pair. Whether the sums themselves are correct, for varied rectangle positions, edge rectangles, a gapped load, a reload and a saturated image, can only be shown by the bench's scenarios, which compare every result against a pixel-level model.

// File: rtl/sat_pkg.sv
package sat_pkg;
   // corner order used by the query datapath
   typedef enum logic [1:0] {
      CRN_TL = 2'd0,
      CRN_TR = 2'd1,
      CRN_BL = 2'd2,
      CRN_BR = 2'd3
   } corner_e;

   localparam int NUM_CORNERS = 4;

   // bits needed to hold a value up to max_val
   function automatic int bits_for(input longint max_val);
      int n;
      n = 1;
      while ((longint'(1) << n) <= max_val) n++;
      return n;
   endfunction
endpackage

// File: rtl/sat_row_accum.sv
module sat_row_accum #(
   parameter int WIN   = 24,
   parameter int PIX_W = 8,
   parameter int CW    = 5,
   parameter int AW    = 10,
   parameter int SUM_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             pix_valid,
   input  logic [PIX_W-1:0] pix_data,
   output logic [AW-1:0]    above_addr,
   input  logic [SUM_W-1:0] above_data,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [SUM_W-1:0] wr_data,
   output logic             win_ready
);
   localparam int DEPTH = WIN * WIN;
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam logic [CW-1:0] LAST_COL = CW'(WIN - 1);

   logic [AW-1:0]    idx;
   logic [CW-1:0]    col;
   logic [SUM_W-1:0] row_run;
   logic             ready_q;
   logic             accept;
   logic             first_row;
   logic [SUM_W-1:0] row_base;
   logic [SUM_W-1:0] above_val;

   assign accept     = pix_valid && !ready_q && !start;
   assign first_row  = ({1'b0, idx} < (AW+1)'(WIN));
   assign row_base   = (col == '0) ? '0 : row_run;
   assign above_addr = first_row ? '0 : idx - AW'(WIN);
   assign above_val  = first_row ? '0 : above_data;

   assign wr_en     = accept;
   assign wr_addr   = idx;
   assign wr_data   = row_base + SUM_W'(pix_data) + above_val;
   assign win_ready = ready_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         idx     <= '0;
         col     <= '0;
         row_run <= '0;
      end else if (start) begin
         ready_q <= 1'b0;
         idx     <= '0;
         col     <= '0;
         row_run <= '0;
      end else if (accept) begin
         row_run <= row_base + SUM_W'(pix_data);
         col     <= (col == LAST_COL) ? '0 : col + 1'b1;
         if (idx == LAST) begin
            idx     <= '0;
            ready_q <= 1'b1;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R2
   ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_q) |-> $past(accept && (idx == LAST)));
   // R7
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !ready_q);
   // R8
   no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |-> !wr_en);
   // R2
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, idx} < (AW+1)'(DEPTH)));
endmodule

// File: rtl/sat_table.sv
module sat_table #(
   parameter int DEPTH = 576,
   parameter int AW    = 10,
   parameter int SUM_W = 18,
   parameter int NRD   = 4
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [SUM_W-1:0] wr_data,
   input  logic [AW-1:0]    above_addr,
   output logic [SUM_W-1:0] above_data,
   input  logic [AW-1:0]    rd_addr [NRD],
   output logic [SUM_W-1:0] rd_data [NRD]
);
   logic [SUM_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign above_data = ({1'b0, above_addr} < (AW+1)'(DEPTH)) ? mem[above_addr] : '0;

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rd_data[g] = ({1'b0, rd_addr[g]} < (AW+1)'(DEPTH)) ? mem[rd_addr[g]] : '0;
   end
endmodule

// File: rtl/sat_rect_pipe.sv
module sat_rect_pipe
   import sat_pkg::*;
#(
   parameter int WIN   = 24,
   parameter int CW    = 5,
   parameter int SW    = 5,
   parameter int AW    = 10,
   parameter int SUM_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             q_fire,
   input  logic [CW-1:0]    q_row,
   input  logic [CW-1:0]    q_col,
   input  logic [SW-1:0]    q_height,
   input  logic [SW-1:0]    q_width,
   output logic [AW-1:0]    rd_addr [NUM_CORNERS],
   input  logic [SUM_W-1:0] rd_data [NUM_CORNERS],
   output logic             res_valid,
   output logic [SUM_W-1:0] res_sum
);
   localparam int ACC_W = SUM_W + 1;

   int   crow [NUM_CORNERS];
   int   ccol [NUM_CORNERS];
   logic czero [NUM_CORNERS];

   always_comb begin
      crow[CRN_TL] = int'(q_row) - 1;
      ccol[CRN_TL] = int'(q_col) - 1;
      crow[CRN_TR] = int'(q_row) - 1;
      ccol[CRN_TR] = int'(q_col) + int'(q_width) - 1;
      crow[CRN_BL] = int'(q_row) + int'(q_height) - 1;
      ccol[CRN_BL] = int'(q_col) - 1;
      crow[CRN_BR] = int'(q_row) + int'(q_height) - 1;
      ccol[CRN_BR] = int'(q_col) + int'(q_width) - 1;
   end

   for (genvar g = 0; g < NUM_CORNERS; g++) begin : g_corner
      assign czero[g]   = (crow[g] < 0) || (ccol[g] < 0) || (crow[g] >= WIN) || (ccol[g] >= WIN);
      assign rd_addr[g] = czero[g] ? '0 : AW'(crow[g] * WIN + ccol[g]);
   end

   // stage 1: corner capture
   logic             v1;
   logic [SUM_W-1:0] cval [NUM_CORNERS];
   // stage 2: two adders
   logic             v2;
   logic [ACC_W-1:0] s_pos, s_neg;
   // stage 3: subtractor
   logic             v3;
   logic [SUM_W-1:0] sum3;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0;
         v2 <= 1'b0;
         v3 <= 1'b0;
      end else begin
         v1 <= q_fire;
         v2 <= v1;
         v3 <= v2;
      end
   end

   for (genvar g = 0; g < NUM_CORNERS; g++) begin : g_cap
      always_ff @(posedge clk) begin
         if (q_fire) cval[g] <= czero[g] ? '0 : rd_data[g];
      end
   end

   always_ff @(posedge clk) begin
      if (v1) begin
         s_pos <= ACC_W'(cval[CRN_BR]) + ACC_W'(cval[CRN_TL]);
         s_neg <= ACC_W'(cval[CRN_TR]) + ACC_W'(cval[CRN_BL]);
      end
      if (v2) sum3 <= SUM_W'(s_pos - s_neg);
   end

   assign res_valid = v3;
   assign res_sum   = sum3;

   // R5
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_fire |-> ##3 res_valid);
   // R5
   no_stray_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(q_fire, 3));
   // R4
   corner_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v2 |-> (s_pos >= s_neg));
endmodule

// File: rtl/sat_window_sum.sv
module sat_window_sum
   import sat_pkg::*;
#(
   parameter int WIN   = 24,
   parameter int PIX_W = 8,
   localparam int CW    = (WIN > 1) ? $clog2(WIN) : 1,
   localparam int SW    = $clog2(WIN + 1),
   localparam int DEPTH = WIN * WIN,
   localparam int AW    = $clog2(DEPTH),
   localparam int SUM_W = PIX_W + AW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             pix_valid,
   input  logic [PIX_W-1:0] pix_data,
   output logic             win_ready,
   input  logic             q_valid,
   input  logic [CW-1:0]    q_row,
   input  logic [CW-1:0]    q_col,
   input  logic [SW-1:0]    q_height,
   input  logic [SW-1:0]    q_width,
   output logic             res_valid,
   output logic [SUM_W-1:0] res_sum
);
   localparam longint MAX_SUM = longint'(DEPTH) * ((longint'(1) << PIX_W) - 1);

   if (WIN < 2) begin : g_bad_win
      $error("window must be at least 2x2");
   end
   if (SUM_W < bits_for(MAX_SUM)) begin : g_bad_width
      $error("entry width too narrow for full-window sum");
   end

   logic [AW-1:0]    above_addr;
   logic [SUM_W-1:0] above_data;
   logic             wr_en;
   logic [AW-1:0]    wr_addr;
   logic [SUM_W-1:0] wr_data;
   logic [AW-1:0]    rd_addr [NUM_CORNERS];
   logic [SUM_W-1:0] rd_data [NUM_CORNERS];
   logic             q_fire;

   assign q_fire = q_valid && win_ready;

   sat_row_accum #(.WIN(WIN), .PIX_W(PIX_W), .CW(CW), .AW(AW), .SUM_W(SUM_W)) u_load (
      .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid), .pix_data(pix_data),
      .above_addr(above_addr), .above_data(above_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .win_ready(win_ready)
   );

   sat_table #(.DEPTH(DEPTH), .AW(AW), .SUM_W(SUM_W), .NRD(NUM_CORNERS)) u_table (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .above_addr(above_addr), .above_data(above_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   sat_rect_pipe #(.WIN(WIN), .CW(CW), .SW(SW), .AW(AW), .SUM_W(SUM_W)) u_query (
      .clk(clk), .rst_n(rst_n), .q_fire(q_fire),
      .q_row(q_row), .q_col(q_col), .q_height(q_height), .q_width(q_width),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .res_valid(res_valid), .res_sum(res_sum)
   );

   // R6
   ignored_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(win_ready, 3));
   // R9
   sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (longint'(res_sum) <= MAX_SUM));
endmodule

// File: tb/sat_window_sum_tb.sv
module sat_window_sum_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WIN = 24;
   localparam int NVEC = 12;
   // vectors: row, col, height, width (expected value from pixel model)
   localparam int VEC [NVEC][4] = '{
      '{0, 0, 1, 1},   '{0, 0, 24, 24}, '{23, 23, 1, 1}, '{0, 5, 3, 7},
      '{5, 0, 4, 2},   '{10, 10, 6, 6}, '{1, 1, 22, 22}, '{0, 23, 24, 1},
      '{23, 0, 1, 24}, '{7, 3, 1, 20},  '{12, 17, 12, 7}, '{3, 9, 9, 1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        pix_valid = 1'b0;
   logic [7:0]  pix_data = '0;
   logic        win_ready;
   logic        q_valid = 1'b0;
   logic [4:0]  q_row = '0, q_col = '0, q_height = '0, q_width = '0;
   logic        res_valid;
   logic [17:0] res_sum;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sat_window_sum u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid), .pix_data(pix_data),
      .win_ready(win_ready), .q_valid(q_valid), .q_row(q_row), .q_col(q_col),
      .q_height(q_height), .q_width(q_width), .res_valid(res_valid), .res_sum(res_sum)
   );

   function automatic int pix(int sel, int r, int c);
      if (sel == 3) return 255;
      return ((r * 37 + c * 11 + sel * 53) ^ (r * c)) & 255;
   endfunction

   function automatic int ref_sum(int sel, int r, int c, int h, int w);
      int s = 0;
      for (int i = r; i < r + h; i++)
         for (int j = c; j < c + w; j++) s += pix(sel, i, j);
      return s;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load_win(int sel, bit gaps);
      for (int r = 0; r < WIN; r++)
         for (int c = 0; c < WIN; c++) begin
            if (gaps && ((r * WIN + c) % 5 == 4)) begin
               @(negedge clk); pix_valid = 1'b0;
            end
            @(negedge clk);
            pix_valid = 1'b1;
            pix_data = 8'(pix(sel, r, c));
            if (r == WIN - 1 && c == WIN - 1)
               chk(win_ready == 1'b0, "R2 ready before last edge", int'(win_ready), 0);
         end
      @(negedge clk);
      pix_valid = 1'b0;
      chk(win_ready == 1'b1, "R2 ready after last pixel", int'(win_ready), 1);
   endtask

   task automatic do_query(int r, int c, int h, int w, int exp, string req);
      @(negedge clk);
      q_valid = 1'b1; q_row = 5'(r); q_col = 5'(c); q_height = 5'(h); q_width = 5'(w);
      @(posedge clk);
      @(negedge clk);
      q_valid = 1'b0;
      @(posedge clk); #1;
      chk(res_valid == 1'b0, "R5 no early result", int'(res_valid), 0);
      @(posedge clk); #1;
      chk(res_valid == 1'b1, "R5 result strobe", int'(res_valid), 1);
      chk(int'(res_sum) == exp, req, int'(res_sum), exp);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(win_ready == 1'b0, "R1 ready in reset", int'(win_ready), 0);
      chk(res_valid == 1'b0, "R1 valid in reset", int'(res_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(win_ready == 1'b0, "R1 ready after reset", int'(win_ready), 0);

      // R2 gapped load, then vector table for R4
      load_win(1, 1'b1);
      for (int k = 0; k < NVEC; k++)
         do_query(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3],
                  ref_sum(1, VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3]), "R4 rectangle sum");

      // R3 table entries through origin-anchored queries
      do_query(0, 0, 1, 9, ref_sum(1, 0, 0, 1, 9), "R3 entry (0,8)");
      do_query(0, 0, 14, 1, ref_sum(1, 0, 0, 14, 1), "R3 entry (13,0)");
      do_query(0, 0, 17, 5, ref_sum(1, 0, 0, 17, 5), "R3 entry (16,4)");

      // R5 back-to-back queries
      @(negedge clk);
      q_valid = 1'b1; q_row = 5'd2; q_col = 5'd3; q_height = 5'd4; q_width = 5'd5;
      @(negedge clk);
      q_row = 5'd0; q_col = 5'd0; q_height = 5'd24; q_width = 5'd24;
      @(negedge clk);
      q_valid = 1'b0;
      @(posedge clk); #1;
      chk(res_valid == 1'b1, "R5 first pipelined strobe", int'(res_valid), 1);
      chk(int'(res_sum) == ref_sum(1, 2, 3, 4, 5), "R5 first pipelined sum", int'(res_sum), ref_sum(1, 2, 3, 4, 5));
      @(posedge clk); #1;
      chk(res_valid == 1'b1, "R5 second pipelined strobe", int'(res_valid), 1);
      chk(int'(res_sum) == ref_sum(1, 0, 0, 24, 24), "R5 second pipelined sum", int'(res_sum), ref_sum(1, 0, 0, 24, 24));
      @(posedge clk); #1;
      chk(res_valid == 1'b0, "R5 strobe is one cycle", int'(res_valid), 0);

      // R8 extra pixels after full window
      for (int k = 0; k < 30; k++) begin
         @(negedge clk); pix_valid = 1'b1; pix_data = 8'd0;
      end
      @(negedge clk); pix_valid = 1'b0;
      chk(win_ready == 1'b1, "R8 ready kept", int'(win_ready), 1);
      do_query(0, 0, 24, 24, ref_sum(1, 0, 0, 24, 24), "R8 table unchanged");
      do_query(0, 0, 2, 24, ref_sum(1, 0, 0, 2, 24), "R8 first rows unchanged");

      // R7 start with a pixel in the same cycle
      @(negedge clk); start = 1'b1; pix_valid = 1'b1; pix_data = 8'd200;
      @(negedge clk); start = 1'b0; pix_valid = 1'b0;
      chk(win_ready == 1'b0, "R7 ready cleared by start", int'(win_ready), 1'b0);

      // R6 query while not ready
      @(negedge clk); q_valid = 1'b1; q_row = 5'd0; q_col = 5'd0; q_height = 5'd1; q_width = 5'd1;
      @(negedge clk); q_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(res_valid == 1'b0, "R6 query ignored", int'(res_valid), 0);
      end

      load_win(2, 1'b0);
      do_query(0, 0, 24, 24, ref_sum(2, 0, 0, 24, 24), "R7 reload full sum");
      do_query(0, 0, 1, 1, pix(2, 0, 0), "R7 start-cycle pixel dropped");
      do_query(9, 4, 8, 11, ref_sum(2, 9, 4, 8, 11), "R7 reload rectangle");

      // R9 saturated image
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      load_win(3, 1'b0);
      do_query(0, 0, 24, 24, 146880, "R9 full window all 255");
      do_query(22, 22, 2, 2, 1020, "R9 bottom-right corner");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule